// File: doc/BRIEF.md
# Segmented Ring Transfer Arbiter

This block decides which participant on a twelve-stop ring interconnect may start a data transfer, and on which ring. The interconnect has four unidirectional rings. Rings 0 and 1 move data clockwise, toward increasing participant numbers. Rings 2 and 3 move data counter-clockwise. Each participant raises a request that names a destination and a byte count. The source of a request is the participant's own position. The arbiter runs once per bus cycle, on the cycles when `bus_en` is high. In each such cycle it accepts at most one request.

A transfer always lasts eight 16-byte beats. A request that can be served is given the shortest direction. The arbiter then picks a ring of that direction on which:
- no live transfer shares a hop segment with the new one;
- the spacing between starts on that ring is respected;
- a transfer slot is free.

The arbiter records the segments the transfer holds and releases them when its beats end. Requests that are malformed are answered with an error pulse and are never given a ring. A requester holds its request until it sees either a grant pulse or an error pulse.

Clockwise segment k is the link from participant k to participant k+1, taken modulo 12. Counter-clockwise segment k is the link from participant k to participant k-1, taken modulo 12.

Top module: `ring_xfer_arbiter`

## Requirements
- R1: While `rst_n` is low and directly after reset, `gnt`, `err`, `gnt_ring` and `gnt_ccw` are all zero, and no transfer is live.
- R2: Responses are single-clock pulses, registered in the clock after a clock edge at which `bus_en` was high. They are zero in every other clock. Across `gnt` and `err` together, at most one bit is set.
- R3: Let h be the clockwise hop count (dst - src) mod 12. If h < 6, only rings 0 and 1 are allowed. If h > 6, only rings 2 and 3 are allowed. If h = 6, a clockwise ring is used when one fits; otherwise a counter-clockwise ring is used. Within a direction, the lower ring index wins. `gnt_ccw` is 1 exactly when `gnt_ring` is 2 or 3.
- R4: A transfer is never granted a ring on which a live transfer holds any of its segments. A pending request that cannot be placed gets no response.
- R5: Two starts on the same ring are at least 3 bus cycles apart.
- R6: One ring carries up to 3 live transfers at once when their segments are disjoint.
- R7: A granted transfer holds its segments for 8 bus cycles. A conflicting transfer can be granted on that ring in the eighth bus cycle after the grant, but not earlier.
- R8: A participant is the source of at most one live transfer and the destination of at most one live transfer. A request that would break either limit waits.
- R9: A request is answered with an `err` pulse and never with a grant in any of these cases: the destination equals the source; the destination is 12 or above; the length is 0; the length is above 128.
- R10: Requests are served in round-robin order. The search starts at the participant after the one served last (participant 0 first after reset). Requests that cannot be placed are skipped and do not block later participants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | High for one clock in each bus cycle (every second clock) |
| req_valid | input | 12 | Pending request, one bit per participant |
| req_dst | input | 12x4 | Destination participant for each request |
| req_len | input | 12x8 | Byte count for each request (1 to 128 is valid) |
| gnt | output | 12 | One-clock grant pulse, one bit per participant |
| err | output | 12 | One-clock error pulse for a rejected request |
| gnt_ring | output | 2 | Ring index of the grant (0 and 1 clockwise, 2 and 3 counter-clockwise) |
| gnt_ccw | output | 1 | Direction of the grant, 1 for counter-clockwise |

## Verification
The bound checker watches four things on every clock:
- pulses appear only after bus-cycle edges;
- at most one acceptance is made per bus cycle;
- every response answers a pending request;
- the direction flag matches the ring index and each ring's start spacing holds.

Segment overlap, hold time, endpoint limits, shortest-path and fallback choice, and round-robin fairness depend on the history of grants. The bench's reference model shows them, together with directed scenarios that place transfers so each limit binds in a known bus cycle.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;

   typedef enum logic {
      DIR_CW  = 1'b0,
      DIR_CCW = 1'b1
   } ring_dir_e;

   function automatic int ceil_log2_min1(input int v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/ring_route_calc.sv
module ring_route_calc #(
   parameter int NODES       = 12,
   parameter int MAX_HOPS    = 6,
   parameter int SRC         = 0,
   parameter int LEN_W       = 8,
   parameter int BURST_BYTES = 128,
   parameter int IDX_W       = $clog2(NODES)
) (
   input  logic [IDX_W-1:0] dst,
   input  logic [LEN_W-1:0] len,
   output logic             bad,
   output logic             cw_ok,
   output logic             ccw_ok,
   output logic [NODES-1:0] cw_mask,
   output logic [NODES-1:0] ccw_mask
);

   int dst_i;
   int hops_cw;
   int hops_ccw;

   always_comb begin
      dst_i    = int'(dst);
      bad      = (dst_i >= NODES) || (dst_i == SRC) ||
                 (len == '0) || (int'(len) > BURST_BYTES);
      hops_cw  = (dst_i >= SRC) ? (dst_i - SRC) : (dst_i + NODES - SRC);
      hops_ccw = NODES - hops_cw;
      cw_ok    = !bad && (hops_cw <= MAX_HOPS);
      ccw_ok   = !bad && (hops_ccw <= MAX_HOPS);
      cw_mask  = '0;
      ccw_mask = '0;
      for (int k = 0; k < NODES; k++) begin
         cw_mask[(SRC + k) % NODES]          = (k < hops_cw);
         ccw_mask[(SRC + NODES - k) % NODES] = (k < hops_ccw);
      end
   end

endmodule

// File: rtl/ring_seg_tracker.sv
module ring_seg_tracker #(
   parameter int NODES     = 12,
   parameter int MAX_LIVE  = 3,
   parameter int START_GAP = 3,
   parameter int BEATS     = 8,
   parameter int IDX_W     = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_en,
   input  logic             start,
   input  logic [NODES-1:0] start_mask,
   input  logic [IDX_W-1:0] start_src,
   input  logic [IDX_W-1:0] start_dst,
   output logic [NODES-1:0] seg_busy,
   output logic [NODES-1:0] src_busy,
   output logic [NODES-1:0] dst_busy,
   output logic             ready
);

   localparam int CNT_W  = $clog2(BEATS + 1);
   localparam int GAP_W  = ring_arb_pkg::ceil_log2_min1(START_GAP + 1);
   localparam int SLOT_W = ring_arb_pkg::ceil_log2_min1(MAX_LIVE);

   logic [CNT_W-1:0] beats_left [MAX_LIVE];
   logic [NODES-1:0] slot_mask  [MAX_LIVE];
   logic [IDX_W-1:0] slot_src   [MAX_LIVE];
   logic [IDX_W-1:0] slot_dst   [MAX_LIVE];
   logic [GAP_W-1:0] gap_left;
   logic             have_free;
   logic [SLOT_W-1:0] free_sel;

   // a slot whose last beat ends at this edge counts as free
   always_comb begin
      seg_busy  = '0;
      src_busy  = '0;
      dst_busy  = '0;
      have_free = 1'b0;
      free_sel  = '0;
      for (int j = 0; j < MAX_LIVE; j++) begin
         if (beats_left[j] > CNT_W'(1)) begin
            seg_busy              = seg_busy | slot_mask[j];
            src_busy[slot_src[j]] = 1'b1;
            dst_busy[slot_dst[j]] = 1'b1;
         end else if (!have_free) begin
            have_free = 1'b1;
            free_sel  = SLOT_W'(j);
         end
      end
      ready = have_free && (gap_left == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_left <= '0;
         for (int j = 0; j < MAX_LIVE; j++) begin
            beats_left[j] <= '0;
            slot_mask[j]  <= '0;
            slot_src[j]   <= '0;
            slot_dst[j]   <= '0;
         end
      end else if (bus_en) begin
         for (int j = 0; j < MAX_LIVE; j++) begin
            if (start && (free_sel == SLOT_W'(j))) begin
               beats_left[j] <= CNT_W'(BEATS);
               slot_mask[j]  <= start_mask;
               slot_src[j]   <= start_src;
               slot_dst[j]   <= start_dst;
            end else if (beats_left[j] != '0) begin
               beats_left[j] <= beats_left[j] - CNT_W'(1);
            end
         end
         if (start)
            gap_left <= GAP_W'(START_GAP - 1);
         else if (gap_left != '0)
            gap_left <= gap_left - GAP_W'(1);
      end
   end

endmodule

// File: rtl/ring_rr_pick.sv
module ring_rr_pick #(
   parameter int N     = 12,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     elig,
   input  logic [IDX_W-1:0] ptr,
   output logic             found,
   output logic [IDX_W-1:0] pick
);

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int k = 0; k < N; k++) begin
         if (!found && elig[(int'(ptr) + k) % N]) begin
            found = 1'b1;
            pick  = IDX_W'((int'(ptr) + k) % N);
         end
      end
   end

endmodule

// File: rtl/ring_xfer_arbiter.sv
module ring_xfer_arbiter #(
   parameter  int NODES         = 12,
   parameter  int RINGS_PER_DIR = 2,
   parameter  int MAX_HOPS      = 6,
   parameter  int MAX_LIVE      = 3,
   parameter  int START_GAP     = 3,
   parameter  int BEATS         = 8,
   parameter  int BEAT_BYTES    = 16,
   parameter  int LEN_W         = 8,
   localparam int IDX_W         = $clog2(NODES),
   localparam int RINGS         = 2 * RINGS_PER_DIR,
   localparam int RING_W        = ring_arb_pkg::ceil_log2_min1(RINGS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_en,
   input  logic [NODES-1:0]            req_valid,
   input  logic [NODES-1:0][IDX_W-1:0] req_dst,
   input  logic [NODES-1:0][LEN_W-1:0] req_len,
   output logic [NODES-1:0]            gnt,
   output logic [NODES-1:0]            err,
   output logic [RING_W-1:0]           gnt_ring,
   output logic                        gnt_ccw
);

   import ring_arb_pkg::*;

   localparam int BURST_BYTES = BEATS * BEAT_BYTES;

   if (2 * MAX_HOPS < NODES) begin : g_chk_hops
      $error("MAX_HOPS leaves some destinations unreachable");
   end
   if (BURST_BYTES >= (1 << LEN_W)) begin : g_chk_len
      $error("LEN_W too narrow for a full burst");
   end
   if (MAX_LIVE < 1 || START_GAP < 1 || BEATS < 2 || RINGS_PER_DIR < 1) begin : g_chk_cnt
      $error("ring limits must be positive, BEATS at least 2");
   end

   logic [NODES-1:0]             bad, cw_ok, ccw_ok;
   logic [NODES-1:0][NODES-1:0]  cw_mask, ccw_mask;
   logic [RINGS-1:0][NODES-1:0]  seg_busy, src_busy_r, dst_busy_r;
   logic [RINGS-1:0]             ring_ready, ring_start;
   logic [NODES-1:0]             src_busy_all, dst_busy_all;
   logic [NODES-1:0]             can_place, elig;
   logic [NODES-1:0][RING_W-1:0] place_ring;
   ring_dir_e                    place_dir [NODES];
   logic [IDX_W-1:0]             rr_ptr, pick;
   logic                         found;
   logic [NODES-1:0]             start_mask;

   for (genvar i = 0; i < NODES; i++) begin : g_node
      ring_route_calc #(
         .NODES(NODES), .MAX_HOPS(MAX_HOPS), .SRC(i),
         .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES), .IDX_W(IDX_W)
      ) u_route (
         .dst(req_dst[i]), .len(req_len[i]), .bad(bad[i]),
         .cw_ok(cw_ok[i]), .ccw_ok(ccw_ok[i]),
         .cw_mask(cw_mask[i]), .ccw_mask(ccw_mask[i])
      );
   end

   for (genvar r = 0; r < RINGS; r++) begin : g_ring
      ring_seg_tracker #(
         .NODES(NODES), .MAX_LIVE(MAX_LIVE), .START_GAP(START_GAP),
         .BEATS(BEATS), .IDX_W(IDX_W)
      ) u_trk (
         .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
         .start(ring_start[r]), .start_mask(start_mask),
         .start_src(pick), .start_dst(req_dst[pick]),
         .seg_busy(seg_busy[r]), .src_busy(src_busy_r[r]),
         .dst_busy(dst_busy_r[r]), .ready(ring_ready[r])
      );
   end

   always_comb begin
      src_busy_all = '0;
      dst_busy_all = '0;
      for (int r = 0; r < RINGS; r++) begin
         src_busy_all = src_busy_all | src_busy_r[r];
         dst_busy_all = dst_busy_all | dst_busy_r[r];
      end
   end

   // placement: clockwise rings first, lower index first
   always_comb begin
      for (int i = 0; i < NODES; i++) begin
         can_place[i]  = 1'b0;
         place_ring[i] = '0;
         place_dir[i]  = DIR_CW;
         if (!bad[i] && !src_busy_all[i] && !dst_busy_all[req_dst[i]]) begin
            if (cw_ok[i]) begin
               for (int r = 0; r < RINGS_PER_DIR; r++) begin
                  if (!can_place[i] && ring_ready[r] &&
                      ((seg_busy[r] & cw_mask[i]) == '0)) begin
                     can_place[i]  = 1'b1;
                     place_ring[i] = RING_W'(r);
                     place_dir[i]  = DIR_CW;
                  end
               end
            end
            if (ccw_ok[i]) begin
               for (int r = RINGS_PER_DIR; r < RINGS; r++) begin
                  if (!can_place[i] && ring_ready[r] &&
                      ((seg_busy[r] & ccw_mask[i]) == '0)) begin
                     can_place[i]  = 1'b1;
                     place_ring[i] = RING_W'(r);
                     place_dir[i]  = DIR_CCW;
                  end
               end
            end
         end
         elig[i] = req_valid[i] && (bad[i] || can_place[i]);
      end
   end

   ring_rr_pick #(.N(NODES), .IDX_W(IDX_W)) u_pick (
      .elig(elig), .ptr(rr_ptr), .found(found), .pick(pick)
   );

   always_comb begin
      start_mask = (place_dir[pick] == DIR_CCW) ? ccw_mask[pick] : cw_mask[pick];
      for (int r = 0; r < RINGS; r++)
         ring_start[r] = bus_en && found && !bad[pick] &&
                         (place_ring[pick] == RING_W'(r));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt      <= '0;
         err      <= '0;
         gnt_ring <= '0;
         gnt_ccw  <= 1'b0;
         rr_ptr   <= '0;
      end else begin
         gnt      <= '0;
         err      <= '0;
         gnt_ring <= '0;
         gnt_ccw  <= 1'b0;
         if (bus_en && found) begin
            rr_ptr <= (int'(pick) == NODES - 1) ? '0 : pick + IDX_W'(1);
            if (bad[pick]) begin
               err[pick] <= 1'b1;
            end else begin
               gnt[pick] <= 1'b1;
               gnt_ring  <= place_ring[pick];
               gnt_ccw   <= (place_dir[pick] == DIR_CCW);
            end
         end
      end
   end

endmodule

// File: rtl/ring_xfer_arbiter_chk.sv
module ring_xfer_arbiter_chk #(
   parameter int NODES         = 12,
   parameter int RINGS_PER_DIR = 2,
   parameter int START_GAP     = 3,
   parameter int RING_W        = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic [NODES-1:0]  req_valid,
   input logic [NODES-1:0]  gnt,
   input logic [NODES-1:0]  err,
   input logic [RING_W-1:0] gnt_ring,
   input logic              gnt_ccw
);

   localparam int RINGS = 2 * RINGS_PER_DIR;
   localparam int GAP_W = $clog2(START_GAP + 1);

   assert_one_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gnt, err}));

   assert_pulse_after_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_en) |-> (gnt == '0 && err == '0));

   assert_err_answers_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt | err) & ~$past(req_valid)) == '0);

   assert_dir_matches_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> (gnt_ccw == (int'(gnt_ring) >= RINGS_PER_DIR)));

   for (genvar r = 0; r < RINGS; r++) begin : g_gap
      logic [GAP_W-1:0] since;
      logic             hit;
      assign hit = (gnt != '0) && (gnt_ring == RING_W'(r));
      always_ff @(posedge clk) begin
         if (!rst_n)
            since <= GAP_W'(START_GAP);
         else if (hit)
            since <= bus_en ? GAP_W'(1) : GAP_W'(0);
         else if (bus_en && since < GAP_W'(START_GAP))
            since <= since + GAP_W'(1);
      end
      assert_start_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> (since >= GAP_W'(START_GAP)));
   end

endmodule

bind ring_xfer_arbiter ring_xfer_arbiter_chk #(
   .NODES(NODES), .RINGS_PER_DIR(RINGS_PER_DIR),
   .START_GAP(START_GAP), .RING_W(RING_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .req_valid(req_valid),
   .gnt(gnt), .err(err), .gnt_ring(gnt_ring), .gnt_ccw(gnt_ccw)
);

// File: tb/ring_xfer_arbiter_test.sv
module ring_xfer_arbiter_test;

   localparam int CLK_PERIOD = 10;
   localparam int N = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_en = 1'b0;
   logic [N-1:0]       req_valid = '0;
   logic [N-1:0][3:0]  req_dst = '0;
   logic [N-1:0][7:0]  req_len = '0;
   logic [N-1:0]       gnt, err;
   logic [1:0]         gnt_ring;
   logic               gnt_ccw;

   int total = 0;
   int bad_cnt = 0;

   int m_cnt [4][3];
   logic [11:0] m_mask [4][3];
   int m_src [4][3];
   int m_dst [4][3];
   int m_gap [4];
   int m_ptr;

   logic [N-1:0] e_gnt, e_err;
   int e_ring;
   bit e_ccw;
   logic [N-1:0] cap_gnt, cap_err;
   int cap_ring;
   bit cap_ccw;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_xfer_arbiter uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .req_valid(req_valid),
      .req_dst(req_dst), .req_len(req_len), .gnt(gnt), .err(err),
      .gnt_ring(gnt_ring), .gnt_ccw(gnt_ccw)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad_cnt++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic logic [11:0] seg_mask(input int s, input int h, input bit ccw);
      logic [11:0] m = '0;
      int seg = s;
      for (int k = 0; k < h; k++) begin
         m[seg] = 1'b1;
         seg = ccw ? (seg + 11) % 12 : (seg + 1) % 12;
      end
      return m;
   endfunction

   task automatic model_reset();
      for (int r = 0; r < 4; r++) begin
         m_gap[r] = 0;
         for (int j = 0; j < 3; j++) begin
            m_cnt[r][j] = 0; m_mask[r][j] = '0; m_src[r][j] = 0; m_dst[r][j] = 0;
         end
      end
      m_ptr = 0;
   endtask

   task automatic model_step();
      logic [11:0] busy [4];
      int freeslot [4];
      bit sbusy [12];
      bit dbusy [12];
      int win, wring, d, l, h;
      logic [11:0] wmask;
      for (int n = 0; n < 12; n++) begin sbusy[n] = 0; dbusy[n] = 0; end
      for (int r = 0; r < 4; r++) begin
         busy[r] = '0; freeslot[r] = -1;
         for (int j = 0; j < 3; j++) begin
            if (m_cnt[r][j] >= 2) begin
               busy[r] |= m_mask[r][j];
               sbusy[m_src[r][j]] = 1; dbusy[m_dst[r][j]] = 1;
            end else if (freeslot[r] < 0) freeslot[r] = j;
         end
      end
      e_gnt = '0; e_err = '0; e_ring = 0; e_ccw = 0;
      win = -1; wring = -1; wmask = '0;
      for (int k = 0; k < 12; k++) begin
         int i = (m_ptr + k) % 12;
         if (win < 0 && req_valid[i]) begin
            d = int'(req_dst[i]); l = int'(req_len[i]);
            if (d >= 12 || d == i || l == 0 || l > 128) begin
               win = i; e_err[i] = 1'b1;
            end else if (!sbusy[i] && !dbusy[d]) begin
               h = (d - i + 12) % 12;
               for (int r = 0; r < 4; r++) begin
                  bit ccw = (r >= 2);
                  int hh = ccw ? 12 - h : h;
                  logic [11:0] mm = seg_mask(i, hh, ccw);
                  if (wring < 0 && hh <= 6 && m_gap[r] == 0 && freeslot[r] >= 0 &&
                      (busy[r] & mm) == '0) begin
                     wring = r; wmask = mm; win = i;
                  end
               end
               if (win == i) begin
                  e_gnt[i] = 1'b1; e_ring = wring; e_ccw = (wring >= 2);
               end
            end
         end
      end
      for (int r = 0; r < 4; r++) begin
         if (m_gap[r] > 0) m_gap[r]--;
         for (int j = 0; j < 3; j++) if (m_cnt[r][j] > 0) m_cnt[r][j]--;
      end
      if (wring >= 0) begin
         m_cnt[wring][freeslot[wring]] = 8;
         m_mask[wring][freeslot[wring]] = wmask;
         m_src[wring][freeslot[wring]] = win;
         m_dst[wring][freeslot[wring]] = int'(req_dst[win]);
         m_gap[wring] = 2;
      end
      if (win >= 0) m_ptr = (win + 1) % 12;
   endtask

   task automatic bus_cycle();
      bus_en = 1'b1;
      @(posedge clk); @(negedge clk);
      model_step();
      cap_gnt = gnt; cap_err = err; cap_ring = int'(gnt_ring); cap_ccw = gnt_ccw;
      check($countones({gnt, err}) <= 1, "R2", "accepts per bus cycle",
            $countones({gnt, err}), 1);
      if (e_err != '0)
         check(err == e_err && gnt == '0, "R9", "error pulse", int'(err), int'(e_err));
      else if (e_gnt != '0) begin
         check(gnt == e_gnt && err == '0, "R10", "served participant",
               int'(gnt), int'(e_gnt));
         check(int'(gnt_ring) == e_ring, "R3", "ring index", int'(gnt_ring), e_ring);
         check(gnt_ccw == e_ccw, "R3", "direction", int'(gnt_ccw), int'(e_ccw));
      end else
         check(gnt == '0 && err == '0, "R4", "no placeable request",
               int'(gnt | err), 0);
      for (int i = 0; i < N; i++) if (gnt[i] || err[i]) req_valid[i] = 1'b0;
      bus_en = 1'b0;
      @(posedge clk); @(negedge clk);
      check(gnt == '0 && err == '0 && gnt_ring == '0 && !gnt_ccw, "R2",
            "idle clock outputs", int'(gnt | err), 0);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_en = 1'b0; req_valid = '0;
      model_reset();
      repeat (3) @(negedge clk);
      check(gnt == '0 && err == '0 && gnt_ring == '0 && !gnt_ccw, "R1",
            "outputs in reset", int'(gnt | err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(gnt == '0 && err == '0, "R1", "outputs after reset", int'(gnt | err), 0);
   endtask

   task automatic raise(input int s, input int d, input int l);
      req_valid[s] = 1'b1; req_dst[s] = 4'(d); req_len[s] = 8'(l);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad_cnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end

   initial begin
      void'($urandom(32'h0051_ee0d));
      @(negedge clk);
      do_reset();

      // R9 malformed requests
      raise(4, 4, 16); bus_cycle();
      check(cap_err == 12'h010 && cap_gnt == '0, "R9", "dst equals src", int'(cap_err), 16);
      raise(3, 15, 16); bus_cycle();
      check(cap_err == 12'h008, "R9", "dst out of range", int'(cap_err), 8);
      raise(2, 5, 0); bus_cycle();
      check(cap_err == 12'h004, "R9", "zero length", int'(cap_err), 4);
      raise(2, 5, 129); bus_cycle();
      check(cap_err == 12'h004, "R9", "length above burst", int'(cap_err), 4);

      // R3 shortest path
      do_reset(); raise(0, 3, 64); bus_cycle();
      check(cap_ring == 0 && !cap_ccw, "R3", "3 hops clockwise", cap_ring, 0);
      do_reset(); raise(0, 9, 64); bus_cycle();
      check(cap_ring == 2 && cap_ccw, "R3", "9 hops goes ccw", cap_ring, 2);
      do_reset(); raise(0, 6, 64); bus_cycle();
      check(cap_ring == 0, "R3", "6 hops prefers clockwise", cap_ring, 0);
      do_reset(); raise(0, 3, 64); bus_cycle();
      raise(6, 0, 64); bus_cycle();
      raise(4, 10, 64); bus_cycle();
      check(cap_gnt == 12'h010 && cap_ring == 2, "R3", "6 hops falls back ccw", cap_ring, 2);

      // R5 spacing between starts
      do_reset(); raise(0, 3, 32); bus_cycle();
      raise(6, 8, 32); bus_cycle();
      check(cap_ring == 1, "R5", "second start moves to ring 1", cap_ring, 1);
      raise(9, 11, 32); bus_cycle();
      check(cap_gnt == '0, "R5", "both cw rings spacing", int'(cap_gnt), 0);
      bus_cycle();
      check(cap_gnt == 12'h200 && cap_ring == 0, "R5", "ring 0 after 3 cycles", cap_ring, 0);

      // R7 / R4 segment hold time
      do_reset(); raise(0, 3, 128); bus_cycle();
      raise(1, 4, 128); bus_cycle();
      raise(2, 3, 16);
      for (int k = 0; k < 6; k++) bus_cycle();
      check(cap_gnt == '0, "R7", "segments held to 7th cycle", int'(cap_gnt), 0);
      bus_cycle();
      check(cap_gnt == 12'h004 && cap_ring == 0, "R7", "segments free at 8th cycle",
            int'(cap_gnt), 4);

      // R8 source limit
      do_reset(); raise(0, 3, 16); bus_cycle();
      raise(0, 10, 16);
      for (int k = 0; k < 7; k++) bus_cycle();
      check(cap_gnt == '0, "R8", "source busy blocks", int'(cap_gnt), 0);
      bus_cycle();
      check(cap_gnt == 12'h001 && cap_ring == 2, "R8", "source free again", cap_ring, 2);

      // R10 round robin
      do_reset(); raise(3, 5, 16); raise(7, 9, 16); raise(1, 2, 16);
      bus_cycle();
      check(cap_gnt == 12'h002, "R10", "first from pointer 0", int'(cap_gnt), 2);
      bus_cycle();
      check(cap_gnt == 12'h008 && cap_ring == 1, "R10", "next in order", int'(cap_gnt), 8);
      bus_cycle();
      bus_cycle();
      check(cap_gnt == 12'h080, "R10", "blocked one served later", int'(cap_gnt), 128);

      // R6 three live transfers share ring 0
      do_reset(); raise(0, 1, 16); bus_cycle();
      bus_cycle(); bus_cycle();
      raise(2, 3, 16); bus_cycle();
      check(cap_ring == 0 && cap_gnt == 12'h004, "R6", "second live on ring 0", cap_ring, 0);
      bus_cycle(); bus_cycle();
      raise(4, 5, 16); bus_cycle();
      check(cap_ring == 0 && cap_gnt == 12'h010, "R6", "third live on ring 0", cap_ring, 0);

      // constrained random traffic against the model
      do_reset();
      for (int c = 0; c < 2500; c++) begin
         for (int i = 0; i < N; i++) begin
            if (!req_valid[i] && ($urandom % 4 == 0)) begin
               int d = ($urandom % 10 == 0) ? int'($urandom % 16) : int'($urandom % 12);
               int l = ($urandom % 20 == 0) ? (($urandom % 2 == 0) ? 0 : int'($urandom_range(129, 255)))
                                            : int'($urandom_range(1, 128));
               raise(i, d, l);
            end
         end
         bus_cycle();
      end

      $display("test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end

endmodule